// File: doc/BRIEF.md
# Coarse Sample Delay Memory

This block delays a stream of complex receive samples by a programmable number of sample periods. Each incoming sample (an in-phase and a quadrature word) is written into a circular buffer of 64 slots. The write pointer moves forward by one slot on every cycle that carries a valid sample. Each of the two output channels, A and B, reads the same buffer content at its own distance behind the write pointer. The delay is counted in valid input samples, not in clock cycles.

Each channel has a 6-bit requested offset. The requested offset does not act at once. It is copied into the channel's effective offset only on a cycle where the sync line chosen by a 3-bit select is high. This lets software stage new delays ahead of time and apply them together at a known moment.

The delay is measured from a reference tap that lies two samples behind the newest sample. Codes 0 to 61 place the read tap that many samples behind the reference tap. Codes 62 and 63 place it two and one samples ahead of the reference tap. This gives a total lag between 0 and 63 samples. Slots that have not been written since reset read as zero.

Top module: `coarse_delay_line`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and all four output data words are 0.
- R2: `out_valid` equals the value `in_valid` had one clock cycle earlier.
- R3: The write pointer moves forward by one slot only on cycles with `in_valid` high. Cycles with `in_valid` low do not change which past sample a later output carries.
- R4: Let x[n] be the n-th valid sample since reset, and let c be a channel's effective offset code. For c in 0..61, the output that the channel produces for x[n] is x[n-2-c].
- R5: For effective code 62 a channel outputs x[n] (a delay of -2 from the reference tap). For code 63 it outputs x[n-1] (a delay of -1).
- R6: A channel's effective offset changes only on a cycle where the selected sync line is high. On that cycle it takes the value of the requested offset. Samples on that same cycle still use the old offset. Changing the requested offset without a selected sync has no effect on the output.
- R7: The selected sync line is `sync_in[sync_sel]`. A pulse on any other sync line has no effect.
- R8: After reset, each channel's effective offset is 0 (a total lag of two samples) until the first selected sync.
- R9: When the index n-lag of a requested sample is below zero, so that its slot has not been written since reset, the output data is zero.
- R10: Channels A and B read the same input stream with their own offsets, and one channel's offset does not affect the other.
- R11: The in-phase and quadrature words of a sample are delayed together. Bits [SAMPLE_W-1:0] of each slot hold I and the bits above them hold Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | SAMPLE_W | Input in-phase word |
| in_q | input | SAMPLE_W | Input quadrature word |
| ofs_a | input | OFS_W | Requested offset code, channel A |
| ofs_b | input | OFS_W | Requested offset code, channel B |
| sync_sel | input | SEL_W | Index of the sync line that loads the offsets |
| sync_in | input | NUM_SYNC | Bank of sync pulses |
| out_valid | output | 1 | Output sample strobe |
| out_a_i | output | SAMPLE_W | Delayed in-phase word, channel A |
| out_a_q | output | SAMPLE_W | Delayed quadrature word, channel A |
| out_b_i | output | SAMPLE_W | Delayed in-phase word, channel B |
| out_b_q | output | SAMPLE_W | Delayed quadrature word, channel B |

## Verification
A sample driven on a cycle appears, with `out_valid` high, exactly one clock edge later. A selected sync pulse changes the offset used for samples from the following cycle onward. The driver applies all stimulus on falling edges. For each valid sample it pushes the expected A and B words into a queue, computed from its own history of inputs and its own model of the effective offsets, which is updated only after the sample of the sync cycle. On each later falling edge, the monitor compares `out_valid` with the strobe driven one cycle earlier and pops one queue entry for every valid output, so each result is checked in the cycle it is due.

// File: rtl/coarse_dly_pkg.sv
package coarse_dly_pkg;

  // Source of the registered read result
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,  // slot not written since reset
    SRC_MEM  = 2'd1,  // stored sample
    SRC_BYP  = 2'd2   // zero lag: sample being written now
  } rd_src_e;

endpackage

// File: rtl/coarse_sync_pick.sv
module coarse_sync_pick #(
  parameter int NUM_SYNC = 8,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic [SEL_W-1:0]    sync_sel,
  output logic                sync_hit
);

  always_comb begin
    sync_hit = 1'b0;
    for (int k = 0; k < NUM_SYNC; k++) begin
      if (sync_sel == SEL_W'(k)) sync_hit = sync_in[k];
    end
  end

endmodule

// File: rtl/coarse_ofs_hold.sv
module coarse_ofs_hold #(
  parameter int OFS_W   = 6,
  parameter int REF_LAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFS_W-1:0] ofs_req,
  output logic [OFS_W-1:0] eff_code,
  output logic [OFS_W-1:0] lag
);

  localparam logic [OFS_W-1:0] REF_OFS = OFS_W'(REF_LAG);

  always_ff @(posedge clk) begin
    if (rst)       eff_code <= '0;
    else if (load) eff_code <= ofs_req;
  end

  // Codes near the top wrap to lags below the reference tap.
  assign lag = eff_code + REF_OFS;

endmodule

// File: rtl/coarse_dly_ram.sv
module coarse_dly_ram
  import coarse_dly_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              bypass,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_q;
  logic [WORD_W-1:0] byp_q;
  logic [DEPTH-1:0]  filled;
  rd_src_e           src_q;

  // Plain array with no reset so the store maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= '0;
      src_q  <= SRC_ZERO;
      byp_q  <= '0;
    end else begin
      if (wr_en) filled[wr_addr] <= 1'b1;
      if (rd_en) begin
        byp_q <= wr_data;
        if (bypass)               src_q <= SRC_BYP;
        else if (filled[rd_addr]) src_q <= SRC_MEM;
        else                      src_q <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_MEM: rd_data = mem_q;
      SRC_BYP: rd_data = byp_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/coarse_delay_line.sv
module coarse_delay_line #(
  parameter int SAMPLE_W = 16,
  parameter int OFS_W    = 6,
  parameter int REF_LAG  = 2,
  parameter int NUM_SYNC = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic [OFS_W-1:0]    ofs_a,
  input  logic [OFS_W-1:0]    ofs_b,
  input  logic [SEL_W-1:0]    sync_sel,
  input  logic [NUM_SYNC-1:0] sync_in,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_a_i,
  output logic [SAMPLE_W-1:0] out_a_q,
  output logic [SAMPLE_W-1:0] out_b_i,
  output logic [SAMPLE_W-1:0] out_b_q
);

  localparam int NUM_CH = 2;
  localparam int WORD_W = 2 * SAMPLE_W;

  logic [OFS_W-1:0]               wr_ptr;
  logic                           sync_hit;
  logic [NUM_CH-1:0][OFS_W-1:0]   ofs_req;
  logic [NUM_CH-1:0][OFS_W-1:0]   eff_code;
  logic [NUM_CH-1:0][OFS_W-1:0]   lag;
  logic [NUM_CH-1:0][WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]              wr_word;

  assign ofs_req[0] = ofs_a;
  assign ofs_req[1] = ofs_b;
  assign wr_word    = {in_q, in_i};

  coarse_sync_pick #(
    .NUM_SYNC (NUM_SYNC),
    .SEL_W    (SEL_W)
  ) u_pick (
    .sync_in  (sync_in),
    .sync_sel (sync_sel),
    .sync_hit (sync_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [OFS_W-1:0] rd_addr;

    coarse_ofs_hold #(
      .OFS_W   (OFS_W),
      .REF_LAG (REF_LAG)
    ) u_ofs (
      .clk      (clk),
      .rst      (rst),
      .load     (sync_hit),
      .ofs_req  (ofs_req[ch]),
      .eff_code (eff_code[ch]),
      .lag      (lag[ch])
    );

    assign rd_addr = wr_ptr - lag[ch];

    coarse_dly_ram #(
      .WORD_W (WORD_W),
      .ADDR_W (OFS_W)
    ) u_ram (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (in_valid),
      .wr_addr (wr_ptr),
      .wr_data (wr_word),
      .rd_en   (in_valid),
      .rd_addr (rd_addr),
      .bypass  (lag[ch] == '0),
      .rd_data (rd_word[ch])
    );
  end

  assign out_a_i = rd_word[0][SAMPLE_W-1:0];
  assign out_a_q = rd_word[0][WORD_W-1:SAMPLE_W];
  assign out_b_i = rd_word[1][SAMPLE_W-1:0];
  assign out_b_q = rd_word[1][WORD_W-1:SAMPLE_W];

endmodule

// File: rtl/coarse_delay_line_chk.sv
module coarse_delay_line_chk #(
  parameter int SAMPLE_W = 16,
  parameter int OFS_W    = 6,
  parameter int NUM_CH   = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         out_valid,
  input logic [OFS_W-1:0]             wr_ptr,
  input logic                         sync_hit,
  input logic [NUM_CH-1:0][OFS_W-1:0] ofs_req,
  input logic [NUM_CH-1:0][OFS_W-1:0] eff_code,
  input logic [SAMPLE_W-1:0]          out_a_i,
  input logic [SAMPLE_W-1:0]          out_a_q,
  input logic [SAMPLE_W-1:0]          out_b_i,
  input logic [SAMPLE_W-1:0]          out_b_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_a_i == '0 && out_a_q == '0 &&
             out_b_i == '0 && out_b_q == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> wr_ptr == OFS_W'($past(wr_ptr) + 1'b1));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(wr_ptr));

  assert_ofs_load_R6: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> eff_code == $past(ofs_req));

  assert_ofs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sync_hit |=> $stable(eff_code));

endmodule

bind coarse_delay_line coarse_delay_line_chk #(
  .SAMPLE_W (SAMPLE_W),
  .OFS_W    (OFS_W),
  .NUM_CH   (NUM_CH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .wr_ptr    (wr_ptr),
  .sync_hit  (sync_hit),
  .ofs_req   (ofs_req),
  .eff_code  (eff_code),
  .out_a_i   (out_a_i),
  .out_a_q   (out_a_q),
  .out_b_i   (out_b_i),
  .out_b_q   (out_b_q)
);

// File: tb/coarse_delay_line_tb.sv
module coarse_delay_line_tb;

  localparam int SW = 16;
  localparam int OW = 6;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_i = '0, in_q = '0;
  logic [OW-1:0] ofs_a = '0, ofs_b = '0;
  logic [2:0]    sync_sel = '0;
  logic [NS-1:0] sync_in = '0;
  logic          out_valid;
  logic [SW-1:0] out_a_i, out_a_q, out_b_i, out_b_q;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [2*SW-1:0] hist[$];
  logic [2*SW-1:0] exp_a[$];
  logic [2*SW-1:0] exp_b[$];
  string           tq_a[$];
  string           tq_b[$];
  logic [OW-1:0]   m_eff_a = '0, m_eff_b = '0;
  string           tag_a = "R8", tag_b = "R8";
  int              gen_k = 0;
  logic            drove_q = 1'b0;

  always #4 clk = ~clk;

  coarse_delay_line u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .ofs_a(ofs_a), .ofs_b(ofs_b), .sync_sel(sync_sel), .sync_in(sync_in),
    .out_valid(out_valid), .out_a_i(out_a_i), .out_a_q(out_a_q),
    .out_b_i(out_b_i), .out_b_q(out_b_q)
  );

  function automatic logic [2*SW-1:0] expect_word(input logic [OW-1:0] code);
    int lag = (int'(code) + 2) % 64;
    int idx = hist.size() - 1 - lag;
    return (idx < 0) ? '0 : hist[idx];
  endfunction

  task automatic step(input bit v, input logic [NS-1:0] sv);
    @(negedge clk);
    in_valid = v;
    sync_in  = sv;
    if (v) begin
      gen_k++;
      in_i = SW'(gen_k * 37 + 11);
      in_q = SW'(gen_k * 91 + 16'h5a5a);
      hist.push_back({in_q, in_i});
      exp_a.push_back(expect_word(m_eff_a));
      exp_b.push_back(expect_word(m_eff_b));
      tq_a.push_back(tag_a);
      tq_b.push_back(tag_b);
    end
    if (sv[sync_sel]) begin
      m_eff_a = ofs_a;
      m_eff_b = ofs_b;
    end
  endtask

  task automatic run(input int cnt, input int gap_every);
    for (int k = 0; k < cnt; k++) begin
      step(1'b1, '0);
      if (gap_every > 0 && (k % gap_every) == 0) step(1'b0, '0);
    end
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (out_valid !== 1'b0 || out_a_i !== '0 || out_a_q !== '0 ||
        out_b_i !== '0 || out_b_q !== '0) begin
      errors++;
      $display("FAIL %s: reset outputs actual v=%b %h %h %h %h expected all 0",
               tag, out_valid, out_a_i, out_a_q, out_b_i, out_b_q);
    end
  endtask

  task automatic do_reset();
    step(1'b0, '0);
    step(1'b0, '0);
    @(negedge clk);
    rst = 1'b1;
    hist.delete();
    m_eff_a = '0;
    m_eff_b = '0;
    @(negedge clk);
    check_quiet("R1");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1");
  endtask

  always @(posedge clk) drove_q <= rst ? 1'b0 : in_valid;

  // Monitor: compare strobe and pop expected words
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (out_valid !== drove_q) begin
        errors++;
        $display("FAIL R2: out_valid actual %b expected %b", out_valid, drove_q);
      end
      if (out_valid === 1'b1) begin
        if (exp_a.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected output actual valid=1 expected none");
        end else begin
          logic [2*SW-1:0] ea, eb;
          string ta, tb;
          ea = exp_a.pop_front();
          eb = exp_b.pop_front();
          ta = tq_a.pop_front();
          tb = tq_b.pop_front();
          checks += 2;
          if ({out_a_q, out_a_i} !== ea) begin
            errors++;
            $display("FAIL %s/R11: ch A actual %h expected %h", ta, {out_a_q, out_a_i}, ea);
          end
          if ({out_b_q, out_b_i} !== eb) begin
            errors++;
            $display("FAIL %s/R11: ch B actual %h expected %h", tb, {out_b_q, out_b_i}, eb);
          end
        end
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1");
    rst = 1'b0;

    // R8, R9: default lag of two, unwritten slots read zero
    tag_a = "R9"; tag_b = "R9";
    run(2, 0);
    tag_a = "R8"; tag_b = "R8";
    run(6, 0);

    // R7: staged offsets, pulse on a non-selected line
    ofs_a = 6'd5; ofs_b = 6'd62; sync_sel = 3'd3;
    tag_a = "R7"; tag_b = "R7";
    step(1'b1, 8'b0010_0000);
    run(5, 0);

    // R10, R5: selected line loads; same-cycle sample uses old offset (R6)
    tag_a = "R6"; tag_b = "R6";
    step(1'b1, 8'b0000_1000);
    tag_a = "R10"; tag_b = "R5";
    run(30, 3);

    // R6: new requests without sync have no effect
    ofs_a = 6'd61; ofs_b = 6'd63;
    tag_a = "R6"; tag_b = "R6";
    run(8, 0);
    sync_sel = 3'd6;
    step(1'b0, 8'b0100_0000);

    // R4 long lag with gaps (R3), R5 code 63, pointer wraps
    tag_a = "R4"; tag_b = "R5";
    run(140, 4);

    // R4: code 0 on A, mid code on B
    ofs_a = 6'd0; ofs_b = 6'd33; sync_sel = 3'd0;
    step(1'b0, 8'b0000_0001);
    tag_a = "R4"; tag_b = "R3";
    run(90, 2);

    // Reset mid-run: offsets return to 0, memory reads zero again
    do_reset();
    tag_a = "R9"; tag_b = "R9";
    run(2, 0);
    tag_a = "R8"; tag_b = "R8";
    run(6, 1);

    step(1'b0, '0);
    step(1'b0, '0);
    @(negedge clk);
    checks++;
    if (exp_a.size() != 0) begin
      errors++;
      $display("FAIL R2: pending outputs actual %0d expected 0", exp_a.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule